// File: doc/BRIEF.md
# Eight-bit accumulator ALU

This block is the arithmetic and logic unit of a small accumulator machine. Each cycle the surrounding core presents the accumulator, a second operand byte, the B register, the incoming carry and auxiliary-carry flags, and an operation code. It raises `opValid` to commit the operation. On that clock edge the block captures the new accumulator, the new B value and the new flags in its output register. The core then writes these values back into its own state.

The operation set covers binary add (with and without carry-in), subtract with borrow, increment and decrement, bitwise logic, clear and complement, four rotates, nibble swap, decimal adjust after a packed-BCD addition, and unsigned multiply and divide. Multiply and divide return their two-byte result in the B/accumulator pair. An unsigned compare reports "less than" on the carry output and equality on a separate output, and it alters neither data register.

Carry and auxiliary carry are returned with every operation: an operation that does not define them passes the incoming flags through. Overflow is held inside the block, so an operation that does not define it keeps the last committed value. Parity always follows the registered accumulator.

Top module: `accAlu`

## Requirements
- R1: While `rstN` is low, and after its release until the first commit, `accOut`, `bOut`, `carryOut`, `auxOut`, `ovOut`, `eqOut` and `parityOut` are all 0.
- R2: On a clock edge with `opValid` low, none of the outputs change, whatever the data inputs hold. With `opValid` high, the results appear on the outputs right after that same edge.
- R3: Code 0 (add) gives `accOut = (accIn + operandIn) mod 256`. Code 1 (add with carry) also adds `carryIn`. Both set carry to the carry out of bit 7, aux to the carry out of bit 3, and overflow to the signed two's-complement overflow.
- R4: Code 2 gives `accOut = (accIn - operandIn - carryIn) mod 256`. Carry is set when `accIn < operandIn + carryIn`, aux is the borrow out of bit 3, and overflow is the signed overflow of the subtraction.
- R5: Code 3 increments and code 4 decrements the accumulator modulo 256. Carry and aux equal `carryIn` and `auxIn`, and overflow keeps its previous value.
- R6: Codes 5, 6 and 7 give AND, OR and XOR of `accIn` with `operandIn`. Code 8 gives 0, code 9 gives the bitwise complement, and code 14 exchanges the two nibbles. Carry and aux pass through from the inputs and overflow is held.
- R7: Code 10 rotates left, with bit 7 going to bit 0. Code 12 rotates right, with bit 0 going to bit 7. Both pass the carry through. Code 11 rotates left through carry: `carryIn` enters bit 0 and bit 7 becomes the carry. Code 13 rotates right through carry: `carryIn` enters bit 7 and bit 0 becomes the carry. Aux passes through and overflow is held for all four.
- R8: `parityOut` is 1 exactly when `accOut` holds an odd number of ones.
- R9: Code 15 (decimal adjust) first adds 06h if the low nibble exceeds 9 or `auxIn` is set. It then adds 60h if the high nibble of that intermediate exceeds 9 or the carry so far is set. The carry so far is `carryIn` OR'd with any carry from the first step, and the final carry also ORs in any carry from the second step. Aux passes through and overflow is held.
- R10: Code 16 gives `{bOut, accOut} = accIn * bIn`, unsigned. Carry is 0, overflow is 1 when the product exceeds 0FFh, and aux passes through.
- R11: Code 17 gives `accOut = accIn / bIn` and `bOut = accIn mod bIn`, unsigned, with carry 0 and overflow 0. When `bIn` is 0, overflow is 1 and carry is 0, and the data outputs are unspecified. Aux passes through in both cases.
- R12: Code 18 (compare) sets carry when `accIn < operandIn`, unsigned, and sets `eqOut` when they are equal. `accOut` and `bOut` take `accIn` and `bIn` unchanged, aux passes through and overflow is held. No other code changes `eqOut`.
- R13: Codes 19 to 31 return `accIn` and `bIn` unchanged, pass carry and aux through and hold overflow. Every code other than 16 and 17 returns `bOut = bIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Commit strobe: capture this cycle's result |
| opSel | input | 5 | Operation code |
| accIn | input | 8 | Current accumulator |
| operandIn | input | 8 | Second operand byte |
| bIn | input | 8 | Current B register |
| carryIn | input | 1 | Current carry flag |
| auxIn | input | 1 | Current auxiliary carry flag |
| accOut | output | 8 | New accumulator |
| bOut | output | 8 | New B register |
| carryOut | output | 1 | New carry flag |
| auxOut | output | 1 | New auxiliary carry flag |
| ovOut | output | 1 | Overflow flag (held between defining operations) |
| parityOut | output | 1 | Odd parity of `accOut` |
| eqOut | output | 1 | Equality result of the last compare |

## Verification
The hardest behaviour to reach from the ports is the overflow flag kept across operations that do not define it. A sweep of logic or rotate codes alone would see whatever overflow value happened to remain, so ahead of each group of such operations the bench commits an addition chosen to leave overflow set or clear, alternating with the accumulator value. Decimal adjust has a second awkward case: a low-nibble correction whose carry out of bit 7 forces the high correction. It is reached by sweeping every accumulator value against all four combinations of incoming carry and aux. Divide by zero is reached by including a zero divisor in the divisor sweep.

// File: rtl/accAluPkg.sv
package accAluPkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_INC  = 5'd3,
    OP_DEC  = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_CLR  = 5'd8,
    OP_CPL  = 5'd9,
    OP_RL   = 5'd10,
    OP_RLC  = 5'd11,
    OP_RR   = 5'd12,
    OP_RRC  = 5'd13,
    OP_SWAP = 5'd14,
    OP_DA   = 5'd15,
    OP_MUL  = 5'd16,
    OP_DIV  = 5'd17,
    OP_CMP  = 5'd18
  } aluOp_e;

  localparam int OP_W = $bits(aluOp_e);

  typedef enum logic [2:0] {
    RES_KEEP, RES_ADDER, RES_LOGIC, RES_ROT, RES_DECADJ, RES_MUL, RES_DIV
  } resSel_e;

  typedef enum logic [2:0] {
    LG_AND, LG_OR, LG_XOR, LG_CLR, LG_CPL, LG_SWAP
  } logicFn_e;

  typedef enum logic [2:0] {
    CS_PASS, CS_ADDER, CS_ROT, CS_DECADJ, CS_ZERO, CS_CMP
  } carrySrc_e;

  typedef enum logic [1:0] {
    OV_HOLD, OV_ADDER, OV_MUL, OV_DIV
  } ovSrc_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    resSel_e   resSel;
    logic      invOperand;
    logic      useCarry;
    logic      unitOperand;
    logicFn_e  logicFn;
    logic      rotLeft;
    logic      rotThru;
    carrySrc_e carrySrc;
    logic      auxFromAdder;
    ovSrc_e    ovSrc;
    logic      wrEqual;
  } aluStrobes_t;

endpackage

// File: rtl/accAluCtrl.sv
module accAluCtrl
  import accAluPkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobes_t     strobes
);

  always_comb begin
    strobes = '0;
    strobes.resSel   = RES_KEEP;
    strobes.logicFn  = LG_AND;
    strobes.carrySrc = CS_PASS;
    strobes.ovSrc    = OV_HOLD;
    case (opSel)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        strobes.resSel       = RES_ADDER;
        strobes.carrySrc     = CS_ADDER;
        strobes.auxFromAdder = 1'b1;
        strobes.ovSrc        = OV_ADDER;
        strobes.useCarry     = (opSel != OP_ADD);
        strobes.invOperand   = (opSel == OP_SUBB);
      end
      OP_INC: begin
        strobes.resSel      = RES_ADDER;
        strobes.unitOperand = 1'b1;
      end
      OP_DEC: begin
        strobes.resSel      = RES_ADDER;
        strobes.unitOperand = 1'b1;
        strobes.invOperand  = 1'b1;
      end
      OP_AND:  begin strobes.resSel = RES_LOGIC; strobes.logicFn = LG_AND;  end
      OP_OR:   begin strobes.resSel = RES_LOGIC; strobes.logicFn = LG_OR;   end
      OP_XOR:  begin strobes.resSel = RES_LOGIC; strobes.logicFn = LG_XOR;  end
      OP_CLR:  begin strobes.resSel = RES_LOGIC; strobes.logicFn = LG_CLR;  end
      OP_CPL:  begin strobes.resSel = RES_LOGIC; strobes.logicFn = LG_CPL;  end
      OP_SWAP: begin strobes.resSel = RES_LOGIC; strobes.logicFn = LG_SWAP; end
      OP_RL: begin
        strobes.resSel  = RES_ROT;
        strobes.rotLeft = 1'b1;
      end
      OP_RLC: begin
        strobes.resSel   = RES_ROT;
        strobes.rotLeft  = 1'b1;
        strobes.rotThru  = 1'b1;
        strobes.carrySrc = CS_ROT;
      end
      OP_RR: begin
        strobes.resSel = RES_ROT;
      end
      OP_RRC: begin
        strobes.resSel   = RES_ROT;
        strobes.rotThru  = 1'b1;
        strobes.carrySrc = CS_ROT;
      end
      OP_DA: begin
        strobes.resSel   = RES_DECADJ;
        strobes.carrySrc = CS_DECADJ;
      end
      OP_MUL: begin
        strobes.resSel   = RES_MUL;
        strobes.carrySrc = CS_ZERO;
        strobes.ovSrc    = OV_MUL;
      end
      OP_DIV: begin
        strobes.resSel   = RES_DIV;
        strobes.carrySrc = CS_ZERO;
        strobes.ovSrc    = OV_DIV;
      end
      OP_CMP: begin
        strobes.carrySrc = CS_CMP;
        strobes.wrEqual  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/accAluMulDiv.sv
module accAluMulDiv #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] prodHi,
  output logic [DATA_W-1:0] prodLo,
  output logic [DATA_W-1:0] quot,
  output logic [DATA_W-1:0] rem,
  output logic              mulOv,
  output logic              divZero
);

  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] product;

  assign product = PROD_W'(srcA) * PROD_W'(srcB);
  assign prodHi  = product[PROD_W-1:DATA_W];
  assign prodLo  = product[DATA_W-1:0];
  assign mulOv   = |prodHi;
  assign divZero = (srcB == '0);

  // Restoring division, one stage per quotient bit, MSB first
  logic [DATA_W-1:0] partRem [DATA_W+1];
  assign partRem[0] = '0;

  for (genvar s = 0; s < DATA_W; s++) begin : g_divStage
    logic [DATA_W:0] shifted;
    logic [DATA_W:0] trial;
    assign shifted = {partRem[s], srcA[DATA_W-1-s]};
    assign trial   = shifted - {1'b0, srcB};
    assign quot[DATA_W-1-s] = ~trial[DATA_W];
    assign partRem[s+1] = trial[DATA_W] ? shifted[DATA_W-1:0] : trial[DATA_W-1:0];
  end

  assign rem = partRem[DATA_W];

endmodule

// File: rtl/accAluDatapath.sv
module accAluDatapath
  import accAluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              commit,
  input  aluStrobes_t       strobes,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              carryIn,
  input  logic              auxIn,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] bOut,
  output logic              carryOut,
  output logic              auxOut,
  output logic              ovOut,
  output logic              eqOut,
  output logic              parityOut
);

  localparam int NIB_W = DATA_W / 2;
  localparam int HI_W  = DATA_W - NIB_W;
  localparam int MID_W = DATA_W - 1 - NIB_W;
  localparam logic [DATA_W:0] LOW_FIX  = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] HIGH_FIX = LOW_FIX << NIB_W;

  // ---------------- shared adder, split at bit 3 and bit 6 -------------
  logic [DATA_W-1:0] addB;
  logic              cinEff;
  logic [NIB_W:0]    lowSum;
  logic [MID_W:0]    midSum;
  logic [1:0]        topSum;
  logic [DATA_W-1:0] addResult;
  logic              addCarry, addAux, addOv;

  assign addB   = (strobes.unitOperand ? DATA_W'(1) : operandIn) ^ {DATA_W{strobes.invOperand}};
  assign cinEff = (strobes.useCarry & carryIn) ^ strobes.invOperand;
  assign lowSum = {1'b0, accIn[NIB_W-1:0]} + {1'b0, addB[NIB_W-1:0]} + (NIB_W+1)'(cinEff);
  assign midSum = {1'b0, accIn[DATA_W-2:NIB_W]} + {1'b0, addB[DATA_W-2:NIB_W]}
                + (MID_W+1)'(lowSum[NIB_W]);
  assign topSum = {1'b0, accIn[DATA_W-1]} + {1'b0, addB[DATA_W-1]} + 2'(midSum[MID_W]);

  assign addResult = {topSum[0], midSum[MID_W-1:0], lowSum[NIB_W-1:0]};
  assign addCarry  = topSum[1] ^ strobes.invOperand;
  assign addAux    = lowSum[NIB_W] ^ strobes.invOperand;
  assign addOv     = topSum[1] ^ midSum[MID_W];

  // ---------------- logic unit ----------------------------------------
  logic [DATA_W-1:0] logicResult;

  always_comb begin
    case (strobes.logicFn)
      LG_AND:  logicResult = accIn & operandIn;
      LG_OR:   logicResult = accIn | operandIn;
      LG_XOR:  logicResult = accIn ^ operandIn;
      LG_CLR:  logicResult = '0;
      LG_CPL:  logicResult = ~accIn;
      LG_SWAP: logicResult = {accIn[NIB_W-1:0], accIn[DATA_W-1:NIB_W]};
      default: logicResult = accIn;
    endcase
  end

  // ---------------- rotator -------------------------------------------
  logic [DATA_W-1:0] rotResult;
  logic              rotCarry;
  logic              rotFill;

  always_comb begin
    if (strobes.rotLeft) begin
      rotFill   = strobes.rotThru ? carryIn : accIn[DATA_W-1];
      rotResult = {accIn[DATA_W-2:0], rotFill};
      rotCarry  = accIn[DATA_W-1];
    end else begin
      rotFill   = strobes.rotThru ? carryIn : accIn[0];
      rotResult = {rotFill, accIn[DATA_W-1:1]};
      rotCarry  = accIn[0];
    end
  end

  // ---------------- decimal adjust ------------------------------------
  logic              lowFix, highFix, daMidCarry, daCarry;
  logic [DATA_W:0]   daStep1, daStep2;

  always_comb begin
    lowFix     = (accIn[NIB_W-1:0] > NIB_W'(9)) || auxIn;
    daStep1    = {1'b0, accIn} + (lowFix ? LOW_FIX : '0);
    daMidCarry = carryIn | daStep1[DATA_W];
    highFix    = (daStep1[DATA_W-1:NIB_W] > HI_W'(9)) || daMidCarry;
    daStep2    = {1'b0, daStep1[DATA_W-1:0]} + (highFix ? HIGH_FIX : '0);
    daCarry    = daMidCarry | daStep2[DATA_W];
  end

  // ---------------- multiply / divide ---------------------------------
  logic [DATA_W-1:0] prodHi, prodLo, quot, rem;
  logic              mulOv, divZero;

  accAluMulDiv #(.DATA_W(DATA_W)) i_mulDiv (
    .srcA   (accIn),
    .srcB   (bIn),
    .prodHi (prodHi),
    .prodLo (prodLo),
    .quot   (quot),
    .rem    (rem),
    .mulOv  (mulOv),
    .divZero(divZero)
  );

  // ---------------- result select and output register -----------------
  logic [DATA_W-1:0] accQ, bQ, accNext, bNext;
  logic              carryQ, auxQ, ovQ, eqQ;
  logic              carryNext, auxNext, ovNext, eqNext;

  always_comb begin
    bNext = bIn;
    case (strobes.resSel)
      RES_ADDER:  accNext = addResult;
      RES_LOGIC:  accNext = logicResult;
      RES_ROT:    accNext = rotResult;
      RES_DECADJ: accNext = daStep2[DATA_W-1:0];
      RES_MUL: begin
        accNext = prodLo;
        bNext   = prodHi;
      end
      RES_DIV: begin
        accNext = quot;
        bNext   = rem;
      end
      default:    accNext = accIn;
    endcase

    case (strobes.carrySrc)
      CS_ADDER:  carryNext = addCarry;
      CS_ROT:    carryNext = rotCarry;
      CS_DECADJ: carryNext = daCarry;
      CS_ZERO:   carryNext = 1'b0;
      CS_CMP:    carryNext = (accIn < operandIn);
      default:   carryNext = carryIn;
    endcase

    auxNext = strobes.auxFromAdder ? addAux : auxIn;

    case (strobes.ovSrc)
      OV_ADDER: ovNext = addOv;
      OV_MUL:   ovNext = mulOv;
      OV_DIV:   ovNext = divZero;
      default:  ovNext = ovQ;
    endcase

    eqNext = strobes.wrEqual ? (accIn == operandIn) : eqQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      bQ     <= '0;
      carryQ <= 1'b0;
      auxQ   <= 1'b0;
      ovQ    <= 1'b0;
      eqQ    <= 1'b0;
    end else if (commit) begin
      accQ   <= accNext;
      bQ     <= bNext;
      carryQ <= carryNext;
      auxQ   <= auxNext;
      ovQ    <= ovNext;
      eqQ    <= eqNext;
    end
  end

  assign accOut    = accQ;
  assign bOut      = bQ;
  assign carryOut  = carryQ;
  assign auxOut    = auxQ;
  assign ovOut     = ovQ;
  assign eqOut     = eqQ;
  assign parityOut = ^accQ;

endmodule

// File: rtl/accAlu.sv
module accAlu
  import accAluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              carryIn,
  input  logic              auxIn,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] bOut,
  output logic              carryOut,
  output logic              auxOut,
  output logic              ovOut,
  output logic              parityOut,
  output logic              eqOut
);

  aluStrobes_t strobes;

  accAluCtrl i_ctrl (
    .opSel  (opSel),
    .strobes(strobes)
  );

  accAluDatapath #(.DATA_W(DATA_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .commit   (opValid),
    .strobes  (strobes),
    .accIn    (accIn),
    .operandIn(operandIn),
    .bIn      (bIn),
    .carryIn  (carryIn),
    .auxIn    (auxIn),
    .accOut   (accOut),
    .bOut     (bOut),
    .carryOut (carryOut),
    .auxOut   (auxOut),
    .ovOut    (ovOut),
    .eqOut    (eqOut),
    .parityOut(parityOut)
  );

endmodule

// File: rtl/accAluChecker.sv
module accAluChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [4:0]        opSel,
  input logic [DATA_W-1:0] accIn,
  input logic [DATA_W-1:0] operandIn,
  input logic [DATA_W-1:0] bIn,
  input logic              carryIn,
  input logic              auxIn,
  input logic [DATA_W-1:0] accOut,
  input logic [DATA_W-1:0] bOut,
  input logic              carryOut,
  input logic              auxOut,
  input logic              ovOut,
  input logic              eqOut
);

  localparam int PROD_W = 2 * DATA_W;

  logic isPassFlagOp;
  assign isPassFlagOp = (opSel >= 5'd5 && opSel <= 5'd9) || opSel == 5'd14;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(accOut) && $stable(bOut) && $stable(carryOut)
                 && $stable(auxOut) && $stable(ovOut) && $stable(eqOut));

  assert_logic_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    opValid && isPassFlagOp |=> carryOut == $past(carryIn) && auxOut == $past(auxIn)
                                && $stable(ovOut));

  assert_rotate_left_R7: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel == 5'd10 |=>
      accOut == {$past(accIn[DATA_W-2:0]), $past(accIn[DATA_W-1])}
      && carryOut == $past(carryIn));

  assert_rotate_thru_R7: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel == 5'd13 |=>
      accOut == {$past(carryIn), $past(accIn[DATA_W-1:1])} && carryOut == $past(accIn[0]));

  assert_mul_product_R10: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel == 5'd16 |=>
      {bOut, accOut} == PROD_W'($past(accIn)) * PROD_W'($past(bIn)) && !carryOut);

  assert_div_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel == 5'd17 && bIn == '0 |=> ovOut && !carryOut);

  assert_compare_R12: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel == 5'd18 |=>
      accOut == $past(accIn) && bOut == $past(bIn)
      && carryOut == ($past(accIn) < $past(operandIn))
      && eqOut == ($past(accIn) == $past(operandIn)));

  assert_unused_code_R13: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel > 5'd18 |=>
      accOut == $past(accIn) && bOut == $past(bIn) && carryOut == $past(carryIn)
      && $stable(ovOut));

endmodule

bind accAlu accAluChecker #(.DATA_W(DATA_W)) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opSel    (opSel),
  .accIn    (accIn),
  .operandIn(operandIn),
  .bIn      (bIn),
  .carryIn  (carryIn),
  .auxIn    (auxIn),
  .accOut   (accOut),
  .bOut     (bOut),
  .carryOut (carryOut),
  .auxOut   (auxOut),
  .ovOut    (ovOut),
  .eqOut    (eqOut)
);

// File: tb/test_accAlu.sv
module test_accAlu;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opSel = '0;
  logic [7:0] accIn = '0, operandIn = '0, bIn = '0;
  logic       carryIn = 1'b0, auxIn = 1'b0;
  logic [7:0] accOut, bOut;
  logic       carryOut, auxOut, ovOut, parityOut, eqOut;

  int tests = 0;
  int fails = 0;
  int expOv = 0;
  int expEq = 0;

  always #5 clk = ~clk;

  accAlu i_accAlu (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .accIn(accIn), .operandIn(operandIn), .bIn(bIn),
    .carryIn(carryIn), .auxIn(auxIn),
    .accOut(accOut), .bOut(bOut), .carryOut(carryOut), .auxOut(auxOut),
    .ovOut(ovOut), .parityOut(parityOut), .eqOut(eqOut)
  );

  function automatic string tagFor(input int op);
    case (op)
      0, 1:           return "R3";
      2:              return "R4";
      3, 4:           return "R5";
      5, 6, 7, 8, 9, 14: return "R6";
      10, 11, 12, 13: return "R7";
      15:             return "R9";
      16:             return "R10";
      17:             return "R11";
      18:             return "R12";
      default:        return "R13";
    endcase
  endfunction

  // Drive one operation at a falling edge, commit it, check at the next falling edge.
  task automatic runOp(input int op, input int a, input int d, input int b,
                       input int c, input int ac);
    int eAcc, eB, eC, eAc, s, t, c1, p, par;
    bit chkData, ok;
    opSel = op[4:0]; accIn = a[7:0]; operandIn = d[7:0]; bIn = b[7:0];
    carryIn = c[0]; auxIn = ac[0]; opValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
    eAcc = a; eB = b; eC = c; eAc = ac; chkData = 1'b1;
    case (op)
      0, 1: begin
        t = (op == 1) ? c : 0;
        s = a + d + t;
        eAcc = s & 255; eC = s >> 8;
        eAc = ((a & 15) + (d & 15) + t) >> 4;
        expOv = eC ^ (((a & 127) + (d & 127) + t) >> 7);
      end
      2: begin
        s = a - d - c;
        eAcc = s & 255;
        eC = (a < d + c) ? 1 : 0;
        eAc = ((a & 15) < (d & 15) + c) ? 1 : 0;
        expOv = eC ^ (((a & 127) < (d & 127) + c) ? 1 : 0);
      end
      3:  eAcc = (a + 1) & 255;
      4:  eAcc = (a + 255) & 255;
      5:  eAcc = a & d;
      6:  eAcc = a | d;
      7:  eAcc = a ^ d;
      8:  eAcc = 0;
      9:  eAcc = (~a) & 255;
      10: eAcc = ((a << 1) | (a >> 7)) & 255;
      11: begin eAcc = ((a << 1) | c) & 255; eC = a >> 7; end
      12: eAcc = (a >> 1) | ((a & 1) << 7);
      13: begin eAcc = (a >> 1) | (c << 7); eC = a & 1; end
      14: eAcc = ((a << 4) | (a >> 4)) & 255;
      15: begin
        t = a;
        if ((t & 15) > 9 || ac != 0) t = t + 6;
        c1 = (c != 0 || t > 255) ? 1 : 0;
        t = t & 255;
        if ((t >> 4) > 9 || c1 != 0) t = t + 96;
        eC = (c1 != 0 || t > 255) ? 1 : 0;
        eAcc = t & 255;
      end
      16: begin
        p = a * b;
        eAcc = p & 255; eB = p >> 8; eC = 0;
        expOv = (p > 255) ? 1 : 0;
      end
      17: begin
        eC = 0;
        if (b == 0) begin
          expOv = 1; chkData = 1'b0;
        end else begin
          eAcc = a / b; eB = a % b; expOv = 0;
        end
      end
      18: begin
        eC = (a < d) ? 1 : 0;
        expEq = (a == d) ? 1 : 0;
      end
      default: ;
    endcase

    tests++;
    ok = (carryOut == eC[0]) && (auxOut == eAc[0]) && (ovOut == expOv[0])
         && (eqOut == expEq[0])
         && (!chkData || (accOut == eAcc[7:0] && bOut == eB[7:0]));
    if (!ok) begin
      fails++;
      $display("FAIL %s op=%0d a=%02h d=%02h b=%02h c=%0d ac=%0d: got acc=%02h b=%02h c=%0d ac=%0d ov=%0d eq=%0d expected acc=%02h b=%02h c=%0d ac=%0d ov=%0d eq=%0d",
               tagFor(op), op, a, d, b, c, ac, accOut, bOut, carryOut, auxOut, ovOut, eqOut,
               eAcc & 255, eB & 255, eC, eAc, expOv, expEq);
    end
    if (chkData) begin
      par = $countones(eAcc[7:0]) & 1;
      tests++;
      if (parityOut != par[0]) begin
        fails++;
        $display("FAIL R8 parity op=%0d acc=%02h: got %0d expected %0d", op, accOut, parityOut, par);
      end
    end
  endtask

  // R2: inputs wiggle with opValid low; outputs must stay put
  task automatic holdCheck(input int a, input int op);
    logic [7:0] sAcc, sB;
    logic [4:0] sFlags;
    sAcc = accOut; sB = bOut;
    sFlags = {carryOut, auxOut, ovOut, eqOut, parityOut};
    opSel = op[4:0]; accIn = a[7:0]; operandIn = ~a[7:0]; bIn = a[7:0] ^ 8'h5A;
    carryIn = ~carryOut; auxIn = ~auxOut; opValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    tests++;
    if (accOut != sAcc || bOut != sB || {carryOut, auxOut, ovOut, eqOut, parityOut} != sFlags) begin
      fails++;
      $display("FAIL R2 hold: got acc=%02h b=%02h flags=%05b expected acc=%02h b=%02h flags=%05b",
               accOut, bOut, {carryOut, auxOut, ovOut, eqOut, parityOut}, sAcc, sB, sFlags);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if ({accOut, bOut, carryOut, auxOut, ovOut, eqOut, parityOut} != '0) begin
      fails++;
      $display("FAIL R1 during reset: got acc=%02h b=%02h c=%0d ac=%0d ov=%0d eq=%0d p=%0d expected all 0",
               accOut, bOut, carryOut, auxOut, ovOut, eqOut, parityOut);
    end
    rstN = 1'b1;
    @(negedge clk);
    tests++;
    if ({accOut, bOut, carryOut, auxOut, ovOut, eqOut, parityOut} != '0) begin
      fails++;
      $display("FAIL R1 after release: got acc=%02h b=%02h expected 00 00 and flags 0", accOut, bOut);
    end

    // R3, R4: arithmetic sweep
    for (int a = 0; a < 256; a++)
      for (int d = 0; d < 256; d += 7)
        for (int c = 0; c < 2; c++) begin
          runOp(0, a, d, a ^ d, c, a & 1);
          runOp(1, a, d, a ^ d, c, a & 1);
          runOp(2, a, d, a ^ d, c, a & 1);
        end

    // R5, R6, R7, R13: operations leaving overflow held; overflow primed first
    for (int a = 0; a < 256; a++) begin
      if (a[0]) runOp(0, 127, 1, 0, 0, 0); else runOp(0, 1, 1, 0, 0, 0);
      for (int c = 0; c < 2; c++) begin
        runOp(3, a, 0, 33, c, c ^ 1);
        runOp(4, a, 0, 33, c, c);
        runOp(8, a, 0, 17, c, c);
        runOp(9, a, 0, 17, c, c ^ 1);
        runOp(14, a, 0, 17, c, c);
        runOp(10, a, 0, 9, c, c);
        runOp(11, a, 0, 9, c, c ^ 1);
        runOp(12, a, 0, 9, c, c);
        runOp(13, a, 0, 9, c, c ^ 1);
      end
      for (int d = 0; d < 256; d += 17) begin
        runOp(5, a, d, a, d & 1, a & 1);
        runOp(6, a, d, a, d & 1, a & 1);
        runOp(7, a, d, a, d & 1, a & 1);
      end
      runOp(19 + (a % 13), a, 255 - a, a ^ 8'hC3, a & 1, (a >> 1) & 1);
    end

    // R9: decimal adjust over every byte and flag combination
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 4; f++)
        runOp(15, a, 0, 0, f & 1, f >> 1);

    // R10, R11: multiply and divide, divisor sweep includes zero
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 5) begin
        runOp(16, a, 0, b, 1, a & 1);
        runOp(17, a, 0, b, 1, a & 1);
      end

    // R12: compare, including the equal case
    for (int a = 0; a < 256; a++) begin
      runOp(0, 127, 1, 0, 0, 0);
      for (int d = 0; d < 256; d += 11) runOp(18, a, d, a ^ 8'h77, d & 1, a & 1);
      runOp(18, a, a, 8'h3C, 1, 0);
      runOp(5, a, 8'hFF, 8'h3C, 0, 1);
    end

    // R2: idle cycles with changing inputs
    for (int k = 0; k < 16; k++) holdCheck(k * 37, k);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule